// File: doc/BRIEF.md
# Receiver Status Interrupt Controller

This block sits beside a digital audio interface receiver and condenses its status signals into one combined error flag and two interrupt lines. Six error causes (rate change, rate out of range, non-PCM data, validity bit set, parity error, PLL unlock) are each gated by a programmable select bit. Their OR forms the combined error, which is available directly and also serves as one interrupt source.

Seven further sources are latched alongside the combined error: non-PCM data, emphasis flag set, compressed-surround data detected, channel-status update, burst-preamble update, rate change and analog-level crossing. Every source sets a sticky pending bit. The pending bits are read through a small register port, and a read of the status register clears them. Each interrupt line has its own mask word. The analog-level crossing source is wired to line 1 only.

Top module: `rx_irq_ctrl`

## Requirements
- R1: After reset the error-select register reads 0x20 (only PLL unlock enabled), both mask registers read 0xFF (all masked), the status register reads 0x00, and both interrupt lines are low.
- R2: `err_o` is the OR of `cause_i & sel`. The cause bits are: 0 rate change, 1 rate out of range, 2 non-PCM, 3 validity set, 4 parity error, 5 PLL unlock.
- R3: A source that is high in a cycle sets its pending bit at the next clock edge. The status bits are: 0 combined error, 1 non-PCM (`cause_i[2]`), 2 emphasis (`evt_i[0]`), 3 compressed data (`evt_i[1]`), 4 channel-status update (`evt_i[2]`), 5 preamble update (`evt_i[3]`), 6 rate change (`cause_i[0]`), 7 analog crossing.
- R4: A pending bit stays set after its source drops, until the status register is read.
- R5: A read of address 3 (status) returns the pending bits in the same cycle and clears them at the following clock edge.
- R6: A source that is active in the same cycle as a status read leaves its pending bit set after the clear.
- R7: `irq0_o` is high exactly when some status bit 6..0 is pending and its bit in mask 0 (address 1) is 0. A mask bit of 1 blocks the source.
- R8: `irq1_o` is high exactly when some status bit 7..0 is pending and its bit in mask 1 (address 2) is 0.
- R9: The analog-crossing source never drives `irq0_o`. Bit 7 of mask 0 always reads 1, whatever value is written to it.
- R10: Address 0 holds the error select in bits 5..0, and bits 7..6 read 0. A write to address 3 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cause_i | input | 6 | Error cause flags |
| evt_i | input | 4 | Emphasis, compressed data, channel-status update, preamble update |
| ana_cross_i | input | 1 | Analog level crossing event |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data, combinational |
| err_o | output | 1 | Combined error |
| irq0_o | output | 1 | Interrupt line 0, active high |
| irq1_o | output | 1 | Interrupt line 1, active high |

## Verification
The hardest case to reach is a source event that lands in the same cycle as the clear-on-read. The bench reaches it by raising a single-cycle channel-status strobe together with a status read. It does this twice: once while the bit is still clear, and once while the bit is already pending. It then reads the status again to confirm that the bit survived the clear. The analog-only path is covered by unmasking every bit of mask 0 while only the analog bit is pending, so that line 0 must stay low while line 1 rises.

// File: rtl/irc_pkg.sv
package irc_pkg;
  localparam int CAUSE_W = 6;
  localparam int EVT_W   = 4;
  localparam int SRC_W   = 8;
  localparam int ADDR_W  = 2;
  localparam int DATA_W  = 8;

  // cause bit positions
  localparam int C_RATE_CHG = 0;
  localparam int C_NPCM     = 2;
  localparam int C_UNLOCK   = 5;

  // pending/status bit positions
  localparam int S_ERR  = 0;
  localparam int S_NPCM = 1;
  localparam int S_EVT0 = 2;
  localparam int S_RATE = 6;
  localparam int S_ANA  = 7;

  localparam logic [CAUSE_W-1:0] SEL_RST   = CAUSE_W'(1) << C_UNLOCK;
  localparam logic [SRC_W-1:0]   REACH_L0  = ~(SRC_W'(1) << S_ANA);
  localparam logic [SRC_W-1:0]   REACH_L1  = '1;

  typedef enum logic [ADDR_W-1:0] {
    A_ERRSEL = 2'd0,
    A_MASK0  = 2'd1,
    A_MASK1  = 2'd2,
    A_STAT   = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/irc_err_comb.sv
module irc_err_comb #(
  parameter int W = irc_pkg::CAUSE_W
) (
  input  logic [W-1:0] cause_i,
  input  logic [W-1:0] sel_i,
  output logic         err_o
);
  logic [W-1:0] gated;
  for (genvar i = 0; i < W; i++) begin : g_gate
    assign gated[i] = cause_i[i] & sel_i[i];
  end
  assign err_o = |gated;
endmodule

// File: rtl/irc_pend_bank.sv
module irc_pend_bank #(
  parameter int W = irc_pkg::SRC_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] pend_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        q <= 1'b0;
      else if (set_i[i])  q <= 1'b1;  // set beats clear
      else if (clr_i[i])  q <= 1'b0;
    end
    assign pend_o[i] = q;

    // R3
    set_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[i] |=> pend_o[i]);
    // R4
    sticky_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pend_o[i] && !clr_i[i]) |=> pend_o[i]);
    // R5
    clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[i] && !set_i[i]) |=> !pend_o[i]);
  end
endmodule

// File: rtl/irc_regs.sv
module irc_regs
  import irc_pkg::*;
#(
  parameter int                   CW     = CAUSE_W,
  parameter int                   SW     = SRC_W,
  parameter int                   AW     = ADDR_W,
  parameter int                   DW     = DATA_W,
  parameter logic [SW-1:0]        M0_FIX = ~REACH_L0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic          re_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [SW-1:0] pend_i,
  output logic [DW-1:0] rdata_o,
  output logic [CW-1:0] sel_o,
  output logic [SW-1:0] mask0_o,
  output logic [SW-1:0] mask1_o,
  output logic [SW-1:0] clr_o
);
  logic [CW-1:0] sel_q;
  logic [SW-1:0] mask0_q, mask1_q;
  reg_addr_e     addr;

  assign addr = reg_addr_e'(addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q   <= SEL_RST;
      mask0_q <= '1;
      mask1_q <= '1;
    end else if (we_i) begin
      case (addr)
        A_ERRSEL: sel_q   <= wdata_i[CW-1:0];
        A_MASK0:  mask0_q <= wdata_i[SW-1:0] | M0_FIX;
        A_MASK1:  mask1_q <= wdata_i[SW-1:0];
        default:  ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr)
      A_ERRSEL: rdata_o = DW'(sel_q);
      A_MASK0:  rdata_o = DW'(mask0_q);
      A_MASK1:  rdata_o = DW'(mask1_q);
      A_STAT:   rdata_o = DW'(pend_i);
      default:  rdata_o = '0;
    endcase
  end

  assign clr_o   = {SW{re_i && (addr == A_STAT)}};
  assign sel_o   = sel_q;
  assign mask0_o = mask0_q;
  assign mask1_o = mask1_q;
endmodule

// File: rtl/irc_int_line.sv
module irc_int_line #(
  parameter int               W     = irc_pkg::SRC_W,
  parameter logic [W-1:0]     REACH = '1
) (
  input  logic [W-1:0] pend_i,
  input  logic [W-1:0] mask_i,
  output logic         irq_o
);
  logic [W-1:0] live;
  for (genvar i = 0; i < W; i++) begin : g_src
    if (REACH[i]) begin : g_on
      assign live[i] = pend_i[i] & ~mask_i[i];
    end else begin : g_off
      assign live[i] = 1'b0;
    end
  end
  assign irq_o = |live;
endmodule

// File: rtl/rx_irq_ctrl.sv
module rx_irq_ctrl
  import irc_pkg::*;
#(
  parameter int CW = CAUSE_W,
  parameter int EW = EVT_W,
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] cause_i,
  input  logic [EW-1:0] evt_i,
  input  logic          ana_cross_i,
  input  logic          reg_we_i,
  input  logic          reg_re_i,
  input  logic [AW-1:0] reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  output logic          err_o,
  output logic          irq0_o,
  output logic          irq1_o
);
  localparam int SW = SRC_W;

  logic [CW-1:0] sel;
  logic [SW-1:0] src, pend, clr, mask0, mask1;

  irc_err_comb #(.W(CW)) u_err (
    .cause_i(cause_i), .sel_i(sel), .err_o(err_o)
  );

  always_comb begin
    src                   = '0;
    src[S_ERR]            = err_o;
    src[S_NPCM]           = cause_i[C_NPCM];
    src[S_EVT0 +: EW]     = evt_i;
    src[S_RATE]           = cause_i[C_RATE_CHG];
    src[S_ANA]            = ana_cross_i;
  end

  irc_pend_bank #(.W(SW)) u_pend (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(src), .clr_i(clr), .pend_o(pend)
  );

  irc_regs #(.CW(CW), .SW(SW), .AW(AW), .DW(DW)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(reg_we_i), .re_i(reg_re_i),
    .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .pend_i(pend),
    .rdata_o(reg_rdata_o), .sel_o(sel), .mask0_o(mask0), .mask1_o(mask1),
    .clr_o(clr)
  );

  localparam logic [SW-1:0] REACH [2] = '{REACH_L0, REACH_L1};
  logic [1:0] irq;
  for (genvar l = 0; l < 2; l++) begin : g_line
    irc_int_line #(.W(SW), .REACH(REACH[l])) u_line (
      .pend_i(pend), .mask_i(l == 0 ? mask0 : mask1), .irq_o(irq[l])
    );
  end
  assign irq0_o = irq[0];
  assign irq1_o = irq[1];

  // R3
  err_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> pend[S_ERR]);
  // R7
  l0_masked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&mask0) |-> !irq0_o);
  // R9
  ana_only_l0_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend == (SW'(1) << S_ANA)) |-> !irq0_o);
  // R8
  l1_masked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&mask1) |-> !irq1_o);
endmodule

// File: tb/tb_rx_irq_ctrl.sv
module tb_rx_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] cause = '0;
  logic [3:0] evt = '0;
  logic       ana = 1'b0;
  logic       we = 1'b0, re = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       err, irq0, irq1;

  rx_irq_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .cause_i(cause), .evt_i(evt),
    .ana_cross_i(ana), .reg_we_i(we), .reg_re_i(re), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .err_o(err),
    .irq0_o(irq0), .irq1_o(irq1)
  );

  always #10 clk = ~clk;

  typedef enum int {K_RD, K_ERR, K_IRQ0, K_IRQ1} kind_e;
  typedef struct {
    kind_e      kind;
    logic [7:0] exp;
    string      tag;
  } item_t;

  item_t q[$];
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic expect_item(kind_e k, logic [7:0] e, string t);
    item_t it;
    it.kind = k; it.exp = e; it.tag = t;
    q.push_back(it);
  endtask

  task automatic nxt();
    @(posedge clk); #1;
    re = 0; we = 0; cause = '0; evt = '0; ana = 0;
  endtask

  task automatic rd(logic [1:0] a, logic [7:0] e, string t);
    re = 1; addr = a;
    expect_item(K_RD, e, t);
    nxt();
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    we = 1; addr = a; wdata = d;
    nxt();
  endtask

  // monitor
  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      logic [7:0] got;
      it = q.pop_front();
      case (it.kind)
        K_RD:    got = rdata;
        K_ERR:   got = {7'b0, err};
        K_IRQ0:  got = {7'b0, irq0};
        default: got = {7'b0, irq1};
      endcase
      n_chk++;
      if (got !== it.exp) begin
        n_fail++;
        $display("FAIL %s: got %h expected %h", it.tag, got, it.exp);
      end
    end
  end

  initial begin
    #(20 * 5000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    nxt();
    // R1 reset state
    expect_item(K_IRQ0, 8'h0, "R1 irq0");
    expect_item(K_IRQ1, 8'h0, "R1 irq1");
    rd(2'd0, 8'h20, "R1 errsel");
    rd(2'd1, 8'hFF, "R1 mask0");
    rd(2'd2, 8'hFF, "R1 mask1");
    rd(2'd3, 8'h00, "R1 status");

    // R2 combined error
    cause = 6'b100000; expect_item(K_ERR, 8'h1, "R2 unlock default"); nxt();
    cause = 6'b011111; expect_item(K_ERR, 8'h0, "R2 others off"); nxt();
    wr(2'd0, 8'h05);
    cause = 6'b000010; expect_item(K_ERR, 8'h0, "R2 unselected"); nxt();
    cause = 6'b000100; expect_item(K_ERR, 8'h1, "R2 selected npcm"); nxt();
    re = 1; addr = 2'd3; nxt();          // flush pending
    rd(2'd3, 8'h00, "R5 flushed");

    // R3/R4 latch and hold
    cause = 6'b000100; nxt();
    nxt();
    rd(2'd3, 8'h03, "R3 R4 err+npcm held");
    rd(2'd3, 8'h00, "R5 cleared");
    cause = 6'b000001; evt = 4'b1010; nxt();
    rd(2'd3, 8'h69, "R3 mixed sources");
    rd(2'd3, 8'h00, "R5 cleared again");

    // R6 event coincident with clear
    evt = 4'b0100; rd(2'd3, 8'h00, "R6 not yet pending");
    rd(2'd3, 8'h10, "R6 survived clear");
    evt = 4'b0100; nxt();
    evt = 4'b0100; rd(2'd3, 8'h10, "R6 pending at clear");
    rd(2'd3, 8'h10, "R6 still set");
    rd(2'd3, 8'h00, "R6 finally cleared");

    // R7 line 0
    wr(2'd1, 8'hFB);
    evt = 4'b0001; nxt();
    expect_item(K_IRQ0, 8'h1, "R7 irq0 unmasked");
    expect_item(K_IRQ1, 8'h0, "R8 irq1 masked");
    nxt();
    rd(2'd3, 8'h04, "R7 status");
    expect_item(K_IRQ0, 8'h0, "R7 irq0 after clear"); nxt();
    evt = 4'b0010; nxt();
    expect_item(K_IRQ0, 8'h0, "R7 masked bit"); nxt();
    rd(2'd3, 8'h08, "R7 status masked src");

    // R8/R9 analog
    wr(2'd2, 8'h7F);
    wr(2'd1, 8'h00);
    rd(2'd1, 8'h80, "R9 mask0 bit7 fixed");
    ana = 1; nxt();
    expect_item(K_IRQ0, 8'h0, "R9 analog not on irq0");
    expect_item(K_IRQ1, 8'h1, "R8 analog on irq1");
    nxt();
    rd(2'd3, 8'h80, "R8 status analog");
    expect_item(K_IRQ1, 8'h0, "R8 irq1 after clear"); nxt();

    // R10 register map
    evt = 4'b1000; nxt();
    wr(2'd3, 8'h00);
    rd(2'd3, 8'h20, "R10 status write ignored");
    wr(2'd0, 8'hFF);
    rd(2'd0, 8'h3F, "R10 errsel width");
    rd(2'd2, 8'h7F, "R10 mask1 readback");

    nxt();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule